// File: doc/BRIEF.md
# Asynchronous byte-lane SRAM controller

This block sits between an internal valid/ready request port and an asynchronous 16-bit static RAM that has separate upper and lower byte strobes. The host issues one word at a time. Each request carries an address, write data, a two-bit lane mask and a write flag. The controller turns each request into a timed sequence on the RAM pins. Reads return the selected lanes with a single-cycle valid pulse.

Every pin phase is a whole number of clock cycles. Each count comes from a nanosecond minimum divided by the clock-period parameter and rounded up. Writes end on the rising edge of the write strobe. Chip select, lane strobes, address and write data stay in place for one more cycle after that edge. After a read, the data-bus drive stays off until the RAM can no longer be driving the bus. A request with no lane selected touches no pin.

Top module: `sram_lane_ctl`

## Requirements
- R1: While and after a synchronous reset, ramCeN, ramOeN, ramWeN, ramUbN and ramLbN are 1, ramDoe and rspValid are 0, and reqReady is 1.
- R2: A read with a nonzero mask drives ramCeN and ramOeN low and keeps ramWeN high for RD_CYC cycles (10 at the defaults), starting the cycle after acceptance. During those cycles ramLbN equals the inverse of mask bit 0 and ramUbN equals the inverse of mask bit 1.
- R3: A read samples ramDin on the edge that ends its RD_CYC window. rspValid is 1 for exactly the following cycle. In rspData, a lane whose mask bit is 0 reads as zero. Bits 7..0 form the lower lane and bits 15..8 the upper lane.
- R4: A write with a nonzero mask holds ramWeN low for exactly WE_CYC cycles (8) from the cycle after acceptance. ramCeN and the selected lane strobes stay low for WE_CYC+1 cycles (9), so they outlast ramWeN by one cycle. ramWeN is never low while ramCeN is high.
- R5: A write changes only the lanes whose mask bit is 1. A later read of the same address returns the other lane unchanged.
- R6: While ramWeN is low, ramDoe is 1, ramDout holds the request's write data, and ramOeN is 1.
- R7: reqReady is 0 from acceptance through the end of the access. A write takes WR_END cycles (10). A read takes RD_CYC cycles plus FLT_CYC guard cycles (10+3).
- R8: ramDoe is never 1 while ramOeN is 0. After a read, ramDoe stays 0 for at least FLT_CYC cycles (3) after ramOeN rises.
- R9: A request with mask 0 changes no RAM pin and leaves memory unchanged. It holds reqReady low for one cycle. If it is a read, it returns rspValid with rspData 0 in the cycle after acceptance.
- R10: ramAddr holds the accepted address and stays stable for as long as ramCeN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqData | input | 16 | Write data |
| reqMask | input | 2 | Lane select: bit 0 lower byte, bit 1 upper byte |
| rspValid | output | 1 | One-cycle pulse marking read data |
| rspData | output | 16 | Read data, unselected lanes zero |
| ramAddr | output | 16 | RAM address bus |
| ramDout | output | 16 | Data toward the RAM |
| ramDin | input | 16 | Data from the RAM |
| ramDoe | output | 1 | Drive enable for ramDout onto the shared bus |
| ramCeN | output | 1 | Chip select, active low |
| ramOeN | output | 1 | Output enable, active low |
| ramWeN | output | 1 | Write strobe, active low |
| ramUbN | output | 1 | Upper-lane strobe, active low |
| ramLbN | output | 1 | Lower-lane strobe, active low |

## Verification
The assertions assume that reqWrite, reqAddr, reqData and reqMask are meaningful only in the cycle a request is accepted, and that reset is applied synchronously for at least one edge. They also assume that ramDin carries valid data only in the lanes the controller selected. The bench changes every host input half a cycle away from the active edge and holds reqValid until a rising edge sees reqReady high. Its RAM model drives only the strobed lanes during reads and leaves the other lanes floating. The bench also issues back-to-back read-then-write requests, so the data-bus turnaround guard is exercised at its tightest spacing.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_GUARD,
    ST_NOP
  } ctlState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;       // latch the accepted request
    logic loadWrite;  // accepted request is a write
    logic drop;       // release lane strobes and bus drive
    logic capture;    // sample the RAM data bus
    logic zeroRsp;    // return zero for an empty-mask read
  } ctlStrobe_t;

  function automatic int cyclesFor(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int WE_CYC  = 8,
  parameter int WR_END  = 10,
  parameter int RD_CYC  = 10,
  parameter int FLT_CYC = 3,
  parameter int CNT_W   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqMask,
  output logic       reqReady,
  output logic       ceN,
  output logic       oeN,
  output logic       weN,
  output logic       rspValid,
  output ctlStrobe_t ctl
);

  localparam logic [CNT_W-1:0] WE_LAST   = CNT_W'(WE_CYC);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(WE_CYC + 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_END);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC);
  localparam logic [CNT_W-1:0] FLT_LAST  = CNT_W'(FLT_CYC);

  ctlState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             zeroMask;

  always_comb begin
    reqReady      = (state == ST_IDLE);
    accept        = reqValid && reqReady;
    zeroMask      = (reqMask == 2'b00);
    ctl.load      = accept && !zeroMask;
    ctl.loadWrite = reqWrite;
    ctl.drop      = ((state == ST_WRITE) && (cnt == HOLD_LAST)) ||
                    ((state == ST_READ) && (cnt == RD_LAST));
    ctl.capture   = (state == ST_READ) && (cnt == RD_LAST);
    ctl.zeroRsp   = accept && zeroMask && !reqWrite;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ceN      <= 1'b1;
      oeN      <= 1'b1;
      weN      <= 1'b1;
      rspValid <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (zeroMask) begin
              state    <= ST_NOP;
              rspValid <= !reqWrite;
            end else begin
              ceN <= 1'b0;
              cnt <= CNT_W'(1);
              if (reqWrite) begin
                weN   <= 1'b0;
                state <= ST_WRITE;
              end else begin
                oeN   <= 1'b0;
                state <= ST_READ;
              end
            end
          end
        end
        ST_WRITE: begin
          if (cnt == WE_LAST) weN <= 1'b1;
          if (cnt == HOLD_LAST) ceN <= 1'b1;
          if (cnt == WR_LAST) state <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
        ST_READ: begin
          if (cnt == RD_LAST) begin
            ceN      <= 1'b1;
            oeN      <= 1'b1;
            rspValid <= 1'b1;
            state    <= ST_GUARD;
            cnt      <= CNT_W'(1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GUARD: begin
          if (cnt == FLT_LAST) state <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker: length of the write-strobe low run
  logic [CNT_W-1:0] weLowRun;
  always_ff @(posedge clk) begin
    if (rst || weN) weLowRun <= '0;
    else weLowRun <= weLowRun + 1'b1;
  end

  assert_we_inside_ce_R4: assert property (@(posedge clk) disable iff (rst)
    !weN |-> !ceN);
  assert_we_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(weN) |-> (weLowRun == WE_LAST));
  assert_oe_we_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(!oeN && !weN));
  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
    !ceN |-> !reqReady);
  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobe_t          ctl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*LANE_W-1:0] reqData,
  input  logic [1:0]          reqMask,
  input  logic [2*LANE_W-1:0] ramDin,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic [2*LANE_W-1:0] ramDout,
  output logic                ramDoe,
  output logic [1:0]          laneN,
  output logic [2*LANE_W-1:0] rspData
);

  logic [1:0] maskQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      ramAddr <= '0;
      ramDout <= '0;
      maskQ   <= '0;
      ramDoe  <= 1'b0;
    end else if (ctl.drop) begin
      ramDoe <= 1'b0;
    end else if (ctl.load) begin
      ramAddr <= reqAddr;
      ramDout <= reqData;
      maskQ   <= reqMask;
      ramDoe  <= ctl.loadWrite;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic              offN;
    logic [LANE_W-1:0] rdByte;

    always_ff @(posedge clk) begin
      if (rst || ctl.drop) offN <= 1'b1;
      else if (ctl.load) offN <= ~reqMask[g];
    end

    always_ff @(posedge clk) begin
      if (rst || ctl.zeroRsp) rdByte <= '0;
      else if (ctl.capture)
        rdByte <= maskQ[g] ? ramDin[g*LANE_W +: LANE_W] : '0;
    end

    assign laneN[g] = offN;
    assign rspData[g*LANE_W +: LANE_W] = rdByte;
  end

endmodule

// File: rtl/sram_lane_ctl.sv
module sram_lane_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int CLK_NS       = 20,
  parameter int T_CYCLE_NS   = 200,
  parameter int T_WEPULSE_NS = 160,
  parameter int T_WSETUP_NS  = 160,
  parameter int T_ACC_NS     = 200,
  parameter int T_OEACC_NS   = 100,
  parameter int T_LANEACC_NS = 100,
  parameter int T_FLOAT_NS   = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [1:0]        reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramDout,
  input  logic [DATA_W-1:0] ramDin,
  output logic              ramDoe,
  output logic              ramCeN,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic              ramUbN,
  output logic              ramLbN
);

  localparam int LANE_W  = DATA_W / 2;
  localparam int WE_CYC  = max2(cyclesFor(T_WEPULSE_NS, CLK_NS),
                                cyclesFor(T_WSETUP_NS, CLK_NS));
  localparam int WR_END  = max2(cyclesFor(T_CYCLE_NS, CLK_NS), WE_CYC + 1);
  localparam int RD_CYC  = max2(max2(cyclesFor(T_ACC_NS, CLK_NS),
                                     cyclesFor(T_CYCLE_NS, CLK_NS)),
                                max2(cyclesFor(T_OEACC_NS, CLK_NS),
                                     cyclesFor(T_LANEACC_NS, CLK_NS)));
  localparam int FLT_CYC = max2(1, cyclesFor(T_FLOAT_NS, CLK_NS));
  localparam int CNT_W   = $clog2(max2(WR_END, RD_CYC) + 2);

  ctlStrobe_t ctl;
  logic [1:0] laneN;

  sram_ctl_seq #(
    .WE_CYC(WE_CYC), .WR_END(WR_END), .RD_CYC(RD_CYC),
    .FLT_CYC(FLT_CYC), .CNT_W(CNT_W)
  ) i_seq (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMask(reqMask), .reqReady(reqReady), .ceN(ramCeN), .oeN(ramOeN),
    .weN(ramWeN), .rspValid(rspValid), .ctl(ctl)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .reqAddr(reqAddr), .reqData(reqData),
    .reqMask(reqMask), .ramDin(ramDin), .ramAddr(ramAddr),
    .ramDout(ramDout), .ramDoe(ramDoe), .laneN(laneN), .rspData(rspData)
  );

  assign ramLbN = laneN[0];
  assign ramUbN = laneN[1];

  assert_no_drive_with_oe_R8: assert property (@(posedge clk) disable iff (rst)
    !(ramDoe && !ramOeN));
  assert_drive_during_we_R6: assert property (@(posedge clk) disable iff (rst)
    !ramWeN |-> ramDoe);
  assert_lane_needs_ce_R2: assert property (@(posedge clk) disable iff (rst)
    (!ramUbN || !ramLbN) |-> !ramCeN);
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!ramCeN && !$past(ramCeN)) |-> $stable(ramAddr));

endmodule

// File: tb/test_sram_lane_ctl.sv
module test_sram_lane_ctl;

  localparam int WE_CYC  = 8;
  localparam int WR_END  = 10;
  localparam int RD_CYC  = 10;
  localparam int FLT_CYC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqData = '0;
  logic [1:0]  reqMask = '0;
  logic        reqReady, rspValid, ramDoe;
  logic [15:0] rspData, ramAddr, ramDout;
  logic [15:0] ramDinR = 16'hzzzz;
  logic        ramCeN, ramOeN, ramWeN, ramUbN, ramLbN;

  int compared = 0;
  int mism = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sram_lane_ctl i_sram_lane_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData(reqData),
    .reqMask(reqMask), .rspValid(rspValid), .rspData(rspData),
    .ramAddr(ramAddr), .ramDout(ramDout), .ramDin(ramDinR), .ramDoe(ramDoe),
    .ramCeN(ramCeN), .ramOeN(ramOeN), .ramWeN(ramWeN), .ramUbN(ramUbN),
    .ramLbN(ramLbN)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mism++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- RAM model (bench side) ----------------
  logic [15:0] ramMem [int];
  logic        prevOv = 1'b0, prevUb = 1'b1, prevLb = 1'b1;
  logic [15:0] prevData = '0, prevAddr = '0;

  function automatic logic [15:0] memRead(input logic [15:0] a);
    return ramMem.exists(int'(a)) ? ramMem[int'(a)] : 16'h0000;
  endfunction

  // ---------------- behavioural reference ----------------
  // kind: 0 idle, 1 write, 2 read, 3 guard, 4 empty-mask
  int          mKind = 0, mAge = 0;
  logic [15:0] mAddr = '0, mData = '0, mRspData = '0;
  logic [1:0]  mMask = '0;
  logic        mRsp = 1'b0;
  logic [15:0] shadow [int];
  logic [15:0] lastRsp = '0;

  function automatic logic [15:0] shRead(input logic [15:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    logic [15:0] w;
    mRsp = 1'b0;
    if (rst) begin
      mKind = 0;
    end else begin
      case (mKind)
        0: if (reqValid) begin
          if (reqMask == 2'b00) begin
            mKind = 4; mRsp = !reqWrite; mRspData = 16'h0000;
          end else begin
            mKind = reqWrite ? 1 : 2; mAge = 1;
            mAddr = reqAddr; mData = reqData; mMask = reqMask;
            if (reqWrite) begin
              w = shRead(reqAddr);
              if (reqMask[0]) w[7:0] = reqData[7:0];
              if (reqMask[1]) w[15:8] = reqData[15:8];
              shadow[int'(reqAddr)] = w;
            end
          end
        end
        1: if (mAge == WR_END) mKind = 0; else mAge++;
        2: if (mAge == RD_CYC) begin
          w = shRead(mAddr);
          mRspData = {mMask[1] ? w[15:8] : 8'h00, mMask[0] ? w[7:0] : 8'h00};
          mRsp = 1'b1; mKind = 3; mAge = 1;
        end else mAge++;
        3: if (mAge == FLT_CYC) mKind = 0; else mAge++;
        default: mKind = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    logic act, eCe, eWe, eOe, eDoe;
    logic ov;
    logic [15:0] w;
    // RAM behaviour: commit at the end of the write overlap
    ov = !ramCeN && !ramWeN && (!ramUbN || !ramLbN);
    if (prevOv && !ov) begin
      w = memRead(prevAddr);
      if (!prevLb) w[7:0] = prevData[7:0];
      if (!prevUb) w[15:8] = prevData[15:8];
      ramMem[int'(prevAddr)] = w;
    end
    prevOv = ov; prevUb = ramUbN; prevLb = ramLbN;
    prevData = ramDout; prevAddr = ramAddr;
    w = memRead(ramAddr);
    ramDinR[7:0]  = (!ramCeN && ramWeN && !ramOeN && !ramLbN) ? w[7:0] : 8'hzz;
    ramDinR[15:8] = (!ramCeN && ramWeN && !ramOeN && !ramUbN) ? w[15:8] : 8'hzz;

    act  = (mKind == 1 && mAge <= WE_CYC + 1) || (mKind == 2);
    eCe  = !act;
    eWe  = !(mKind == 1 && mAge <= WE_CYC);
    eOe  = !(mKind == 2);
    eDoe = (mKind == 1 && mAge <= WE_CYC + 1);
    if (rst) begin
      cmp("R1", "ceN", {15'd0, ramCeN}, 16'd1);
      cmp("R1", "weN", {15'd0, ramWeN}, 16'd1);
      cmp("R1", "doe", {15'd0, ramDoe}, 16'd0);
    end else begin
      cmp("R2", "ceN", {15'd0, ramCeN}, {15'd0, eCe});
      cmp("R2", "oeN", {15'd0, ramOeN}, {15'd0, eOe});
      cmp("R2", "lbN", {15'd0, ramLbN}, {15'd0, act ? ~mMask[0] : 1'b1});
      cmp("R2", "ubN", {15'd0, ramUbN}, {15'd0, act ? ~mMask[1] : 1'b1});
      cmp("R4", "weN", {15'd0, ramWeN}, {15'd0, eWe});
      cmp("R8", "doe", {15'd0, ramDoe}, {15'd0, eDoe});
      cmp("R7", "ready", {15'd0, reqReady}, {15'd0, mKind == 0});
      cmp("R3", "rspValid", {15'd0, rspValid}, {15'd0, mRsp});
      if (mRsp) cmp("R3", "rspData", rspData, mRspData);
      if (!eWe) cmp("R6", "dout", ramDout, mData);
      if (act) cmp("R10", "addr", ramAddr, mAddr);
    end
    if (rspValid) lastRsp = rspData;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      mism++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic doReq(input logic w, input logic [15:0] a,
                       input logic [15:0] d, input logic [1:0] m);
    logic r;
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqData = d; reqMask = m;
    forever begin
      r = reqReady;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doRead(input logic [15:0] a, input logic [1:0] m,
                        input logic [15:0] exp, input string tag);
    doReq(1'b0, a, 16'h0000, m);
    for (int i = 0; i < 40 && !rspValid; i++) @(negedge clk);
    cmp(tag, "read result", rspData, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1", "ready after reset", {15'd0, reqReady}, 16'd1);
    cmp("R1", "oeN after reset", {15'd0, ramOeN}, 16'd1);
    cmp("R1", "strobes after reset", {14'd0, ramUbN, ramLbN}, 16'd3);
    cmp("R1", "rspValid after reset", {15'd0, rspValid}, 16'd0);

    doReq(1'b1, 16'h0005, 16'h1234, 2'b11);
    doRead(16'h0005, 2'b11, 16'h1234, "R3");
    doReq(1'b1, 16'h0005, 16'hAB00, 2'b10);
    doRead(16'h0005, 2'b11, 16'hAB34, "R5");
    doRead(16'h0005, 2'b01, 16'h0034, "R3");
    doRead(16'h0005, 2'b10, 16'hAB00, "R3");
    doReq(1'b1, 16'h0005, 16'hFFFF, 2'b00);
    doRead(16'h0005, 2'b11, 16'hAB34, "R9");
    doRead(16'h0005, 2'b00, 16'h0000, "R9");
    doReq(1'b1, 16'hFFFF, 16'h55CD, 2'b01);
    doReq(1'b1, 16'hFFFF, 16'hEF99, 2'b10);
    doRead(16'hFFFF, 2'b11, 16'hEFCD, "R5");
    doReq(1'b0, 16'h0005, 16'h0000, 2'b11);
    doReq(1'b1, 16'h0006, 16'hC3A5, 2'b11);
    doRead(16'h0006, 2'b11, 16'hC3A5, "R8");
    for (int k = 0; k < 60; k++) begin
      doReq(1'($urandom), 16'($urandom % 8), 16'($urandom), 2'($urandom));
    end
    repeat (20) @(negedge clk);
    cmp("R7", "idle at end", {15'd0, reqReady}, 16'd1);
    cmp("R3", "last response seen", {15'd0, lastRsp !== 16'hxxxx}, 16'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

endmodule